// File: doc/BRIEF.md
# Logarithmic PWM Fade Sequencer

This block turns a single trigger level into a smooth brightness or speed ramp by producing a 7-bit PWM duty code. The code climbs when the trigger rises and falls when the trigger drops. It moves between a programmed lower code and a programmed upper code. Each ramp step scales a fixed-point duty value by 33/32 up or 31/32 down. As a result, the code lingers at low values and races through high ones, which approximates a logarithmic brightness curve. A downstream PWM generator consumes the code. The configuration comes from a storage block outside this one.

Step pacing comes from a tick-enable input that nominally pulses at 2.5 MHz (0.4 µs per tick). One step lasts `6*slew + 14` ticks, which is 2.4·slew + 5.6 µs. Before a rising ramp the block waits for a programmed number of ticks. A falling ramp begins at once. All pins are plain control and status signals. There is no data stream and no back-pressure: the configuration inputs are sampled live and must be held steady while a fade runs.

Top module: `logfade_seq`

## Requirements
- R1: The trigger passes through a two-flop synchronizer followed by an edge detector. A trigger change driven between clock edges is acted on at the third rising clock edge after it, and a rising edge sets `busy` at that edge.
- R2: A rising ramp first waits `rise_delay` ticks. During this wait `duty_code` holds its previous value. At the first clock edge after the wait ends, the ramp start value is loaded.
- R3: When `rise_slew` is 0, the fade-in is disabled. The wait is then a fixed 256 ticks, and after the wait `duty_code` jumps straight to `duty_max` and `busy` drops.
- R4: A fade-in sets a 5-fraction-bit accumulator to `lo<<5`, where `lo` is `duty_min` with a value of 0 replaced by 1. Each step adds `acc>>5`. The output is `acc>>5`, clamped so it never exceeds `duty_max`.
- R5: A fade-out starts with no wait. At the detection edge it sets the accumulator to `duty_max<<5`. Each step subtracts `acc>>5`. The output is clamped so it never falls below `lo`.
- R6: One step lasts exactly `6*slew + 14` ticks. `rise_slew` paces rising ramps and `fall_slew` paces falling ramps, where a tick is a clock cycle with `tick_en` high.
- R7: A ramp ends at the step where the clamped output equals its target: `duty_max` when rising, `lo` when falling. `busy` drops at that same edge and `duty_code` then stays at the target.
- R8: A trigger edge that arrives during a wait or a ramp abandons it and restarts in the new direction from that direction's start value.
- R9: `busy` is high exactly while a wait or a ramp is in progress. While idle with no trigger edge, `duty_code` does not change.
- R10: After reset, `duty_code` is 0 and `busy` is 0.
- R11: A fade-in starting at code 1 holds code 1 for 32 steps, code 2 for 16 steps and code 3 for 11 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base enable, one pulse per 0.4 µs tick |
| trig_in | input | 1 | Asynchronous fade trigger level |
| duty_min | input | 7 | Lower duty code (0 acts as 1) |
| duty_max | input | 7 | Upper duty code |
| rise_slew | input | 16 | Fade-in slew setting; 0 disables fade-in |
| fall_slew | input | 16 | Fade-out slew setting |
| rise_delay | input | 16 | Ticks to wait before a fade-in |
| duty_code | output | 7 | Current PWM duty code |
| busy | output | 1 | High during a wait or a ramp |

## Verification
Errors in the accumulator show up at the ports quickly. A wrong load or step value shows on `duty_code` at the first step edge, one step period after the ramp starts. The per-code dwell counts near code 1 expose a wrong shift or increment within 32 steps. A step or delay counter that is off by one moves the edge where `busy` falls. The bench catches this by sampling `busy` exactly one cycle before and one cycle after the predicted edge. A wrong state after a mid-ramp trigger edge shows as a wrong start code at the third clock edge after the edge. A sticky state shows as `busy` failing to drop.

// File: rtl/logfade_pkg.sv
package logfade_pkg;
  localparam int DEF_DUTY_W    = 7;
  localparam int DEF_FRAC_W    = 5;
  localparam int DEF_CFG_W     = 16;
  localparam int DIS_DELAY_TKS = 256;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_UP   = 2'd2,
    ST_DOWN = 2'd3
  } fade_state_t;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_LOAD_UP   = 3'd1,
    OP_LOAD_DN   = 3'd2,
    OP_STEP_UP   = 3'd3,
    OP_STEP_DN   = 3'd4,
    OP_FORCE_MAX = 3'd5
  } acc_op_t;
endpackage

// File: rtl/logfade_sync.sv
module logfade_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/logfade_timer.sv
module logfade_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         at_limit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (tick && cnt != limit)  cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == limit);
endmodule

// File: rtl/logfade_accum.sv
module logfade_accum
  import logfade_pkg::*;
#(
  parameter int DUTY_W = DEF_DUTY_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_op_t           op,
  input  logic [DUTY_W-1:0] lo_code,
  input  logic [DUTY_W-1:0] hi_code,
  output logic [DUTY_W-1:0] duty,
  output logic              end_now
);
  localparam int ACC_W = DUTY_W + FRAC_W + 1;

  logic [ACC_W-1:0]  acc, acc_nxt, up_start, dn_start, frac_part;
  logic [DUTY_W:0]   raw;
  logic [DUTY_W-1:0] out_up, out_dn, duty_nxt;
  logic              dir_up, upd;

  assign up_start  = ACC_W'({lo_code, {FRAC_W{1'b0}}});
  assign dn_start  = ACC_W'({hi_code, {FRAC_W{1'b0}}});
  assign frac_part = acc >> FRAC_W;

  always_comb begin
    acc_nxt = acc;
    dir_up  = 1'b0;
    upd     = 1'b1;
    case (op)
      OP_LOAD_UP:   begin acc_nxt = up_start;        dir_up = 1'b1; end
      OP_FORCE_MAX: begin acc_nxt = dn_start;        dir_up = 1'b1; end
      OP_STEP_UP:   begin acc_nxt = acc + frac_part; dir_up = 1'b1; end
      OP_LOAD_DN:   acc_nxt = dn_start;
      OP_STEP_DN:   acc_nxt = acc - frac_part;
      default:      upd = 1'b0;
    endcase
  end

  assign raw      = acc_nxt[ACC_W-1:FRAC_W];
  assign out_up   = (raw > {1'b0, hi_code}) ? hi_code : raw[DUTY_W-1:0];
  assign out_dn   = (raw < {1'b0, lo_code}) ? lo_code : raw[DUTY_W-1:0];
  assign duty_nxt = dir_up ? out_up : out_dn;
  assign end_now  = upd && (dir_up ? (duty_nxt == hi_code) : (duty_nxt == lo_code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      duty <= '0;
    end else if (upd) begin
      acc  <= acc_nxt;
      duty <= duty_nxt;
    end
  end
endmodule

// File: rtl/logfade_seq.sv
module logfade_seq
  import logfade_pkg::*;
#(
  parameter int DUTY_W = DEF_DUTY_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int CFG_W  = DEF_CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              trig_in,
  input  logic [DUTY_W-1:0] duty_min,
  input  logic [DUTY_W-1:0] duty_max,
  input  logic [CFG_W-1:0]  rise_slew,
  input  logic [CFG_W-1:0]  fall_slew,
  input  logic [CFG_W-1:0]  rise_delay,
  output logic [DUTY_W-1:0] duty_code,
  output logic              busy
);
  localparam int STEP_W = CFG_W + 3;

  fade_state_t       st;
  acc_op_t           op;
  logic              rise_p, fall_p, end_now, op_up;
  logic              dly_at, stp_at, stp_fire, in_up, in_dn;
  logic [DUTY_W-1:0] lo_code;
  logic [CFG_W-1:0]  dly_lim, slew_sel;
  logic [STEP_W-1:0] stp_lim, slew_w;

  logfade_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(rise_p), .fall(fall_p)
  );

  assign lo_code  = (duty_min == '0) ? DUTY_W'(1) : duty_min;
  assign dly_lim  = (rise_slew == '0) ? CFG_W'(DIS_DELAY_TKS) : rise_delay;
  assign slew_sel = (st == ST_DOWN) ? fall_slew : rise_slew;
  assign slew_w   = STEP_W'(slew_sel);
  assign stp_lim  = (slew_w << 2) + (slew_w << 1) + STEP_W'(13);

  logfade_timer #(.W(CFG_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .clear(rise_p), .tick(tick_en),
    .limit(dly_lim), .at_limit(dly_at)
  );

  logfade_timer #(.W(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_n), .clear(op != OP_NONE), .tick(tick_en),
    .limit(stp_lim), .at_limit(stp_at)
  );

  assign in_up    = (st == ST_UP);
  assign in_dn    = (st == ST_DOWN);
  assign stp_fire = (in_up || in_dn) && tick_en && stp_at;

  always_comb begin
    op = OP_NONE;
    if (fall_p) begin
      op = OP_LOAD_DN;
    end else if (!rise_p) begin
      case (st)
        ST_WAIT: if (dly_at)   op = (rise_slew == '0) ? OP_FORCE_MAX : OP_LOAD_UP;
        ST_UP:   if (stp_fire) op = OP_STEP_UP;
        ST_DOWN: if (stp_fire) op = OP_STEP_DN;
        default: op = OP_NONE;
      endcase
    end
  end

  assign op_up = (op == OP_LOAD_UP) || (op == OP_STEP_UP) || (op == OP_FORCE_MAX);

  logfade_accum #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .op(op), .lo_code(lo_code), .hi_code(duty_max),
    .duty(duty_code), .end_now(end_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            st <= ST_IDLE;
    else if (rise_p)       st <= ST_WAIT;
    else if (op != OP_NONE) begin
      if (end_now)         st <= ST_IDLE;
      else                 st <= op_up ? ST_UP : ST_DOWN;
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/logfade_seq_chk.sv
module logfade_seq_chk #(
  parameter int DUTY_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise,
  input logic              fall,
  input logic              in_up,
  input logic              in_dn,
  input logic              busy,
  input logic [DUTY_W-1:0] duty,
  input logic [DUTY_W-1:0] hi_code,
  input logic [DUTY_W-1:0] lo_code
);
  assert_rise_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> busy);

  assert_fall_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> duty == (($past(hi_code) < $past(lo_code)) ? $past(lo_code) : $past(hi_code)));

  assert_up_mono_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_up && !rise && !fall) |=> duty >= $past(duty));

  assert_dn_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dn && !rise && !fall) |=> duty <= $past(duty));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rise && !fall) |=> $stable(duty));
endmodule

bind logfade_seq logfade_seq_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise_p), .fall(fall_p),
  .in_up(in_up), .in_dn(in_dn), .busy(busy), .duty(duty_code),
  .hi_code(duty_max), .lo_code(lo_code)
);

// File: tb/logfade_seq_test.sv
module logfade_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        half_rate = 1'b0;
  logic        trig_in = 1'b0;
  logic [6:0]  duty_min = '0, duty_max = '0;
  logic [15:0] rise_slew = '0, fall_slew = '0, rise_delay = '0;
  logic [6:0]  duty_code;
  logic        busy;
  int          tests = 0, fails = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) tick_en <= half_rate ? ~tick_en : 1'b1;

  logfade_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trig_in(trig_in),
    .duty_min(duty_min), .duty_max(duty_max), .rise_slew(rise_slew),
    .fall_slew(fall_slew), .rise_delay(rise_delay),
    .duty_code(duty_code), .busy(busy)
  );

  // {min[61:55], max[54:48], rise_slew[47:32], fall_slew[31:16], rise_delay[15:0]}
  localparam logic [61:0] VECS [0:5] = '{
    {7'd0,   7'd127, 16'd1, 16'd1, 16'd0},
    {7'd10,  7'd100, 16'd2, 16'd0, 16'd5},
    {7'd50,  7'd50,  16'd1, 16'd1, 16'd3},
    {7'd100, 7'd20,  16'd1, 16'd2, 16'd0},
    {7'd1,   7'd126, 16'd3, 16'd2, 16'd10},
    {7'd20,  7'd90,  16'd0, 16'd1, 16'd7}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int fade_steps(input int mn, input int mx, input bit up);
    int m, acc, o, n;
    m = (mn == 0) ? 1 : mn;
    n = 0;
    if (up) begin
      acc = m * 32;
      o = (m > mx) ? mx : m;
      while (o != mx && n < 10000) begin
        acc = acc + acc / 32;
        o = (acc / 32 > mx) ? mx : acc / 32;
        n++;
      end
    end else begin
      acc = mx * 32;
      o = (mx < m) ? m : mx;
      while (o != m && n < 10000) begin
        acc = acc - acc / 32;
        o = (acc / 32 < m) ? m : acc / 32;
        n++;
      end
    end
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    trig_in = 1'b0;
    rst_n = 1'b0;
    wait_n(3);
    chk("R10 duty after reset", duty_code, 0);
    chk("R10 busy after reset", busy, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int prev, lo, n_up, n_dn, p_up, p_dn, d, k, c;
    do_reset();
    prev = 0;

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      duty_min   = VECS[i][61:55];
      duty_max   = VECS[i][54:48];
      rise_slew  = VECS[i][47:32];
      fall_slew  = VECS[i][31:16];
      rise_delay = VECS[i][15:0];
      lo   = (duty_min == 0) ? 1 : int'(duty_min);
      p_up = 6 * int'(rise_slew) + 14;
      p_dn = 6 * int'(fall_slew) + 14;
      d    = (rise_slew == 0) ? 256 : int'(rise_delay);
      n_up = (rise_slew == 0) ? 0 : fade_steps(duty_min, duty_max, 1'b1);
      n_dn = fade_steps(duty_min, duty_max, 1'b0);

      // rising ramp (R1, R2, R3, R4, R6, R7)
      trig_in = 1'b1;
      wait_n(2);
      chk("R1 busy low before third edge", busy, 0);
      wait_n(1);
      chk("R1 busy set by rise", busy, 1);
      chk("R2 duty held at ramp start", duty_code, prev);
      wait_n(d + n_up * p_up);
      chk("R7 busy just before fade-in end", busy, 1);
      wait_n(1);
      chk("R7 busy cleared at fade-in end", busy, 0);
      chk((rise_slew == 0) ? "R3 disabled fade-in jumps to max" : "R4 fade-in final code",
          duty_code, int'(duty_max));
      prev = duty_max;

      // falling ramp (R5, R6, R7)
      @(negedge clk);
      trig_in = 1'b0;
      wait_n(3);
      chk("R5 fade-out start code", duty_code, (int'(duty_max) < lo) ? lo : int'(duty_max));
      chk("R9 busy during fade-out", busy, (n_dn > 0) ? 1 : 0);
      if (n_dn > 0) begin
        wait_n(n_dn * p_dn - 1);
        chk("R6 busy just before fade-out end", busy, 1);
        wait_n(1);
        chk("R7 busy cleared at fade-out end", busy, 0);
      end
      chk("R5 fade-out final code", duty_code, lo);
      prev = lo;
    end

    wait_n(50);
    chk("R9 idle duty held", duty_code, prev);
    chk("R9 idle busy low", busy, 0);

    // logarithmic dwell counts from code 1 (R11), step 20 ticks
    @(negedge clk);
    duty_min = 7'd0; duty_max = 7'd127; rise_slew = 16'd1; fall_slew = 16'd1; rise_delay = 16'd0;
    trig_in = 1'b1;
    wait_n(4);
    chk("R4 min 0 loads code 1", duty_code, 1);
    wait_n(32 * 20 - 1);
    chk("R11 code 1 through step 31", duty_code, 1);
    wait_n(1);
    chk("R11 code 2 at step 32", duty_code, 2);
    wait_n(16 * 20 - 1);
    chk("R11 code 2 through step 47", duty_code, 2);
    wait_n(1);
    chk("R11 code 3 at step 48", duty_code, 3);
    wait_n(11 * 20 - 1);
    chk("R11 code 3 through step 58", duty_code, 3);
    wait_n(1);
    chk("R11 code 4 at step 59", duty_code, 4);

    // mid-ramp reversal and re-trigger (R8, R2)
    trig_in = 1'b0;
    wait_n(3);
    chk("R8 fall mid-ramp restarts at max", duty_code, 127);
    chk("R8 busy after reversal", busy, 1);
    rise_delay = 16'd4;
    trig_in = 1'b1;
    wait_n(3 + 4);
    chk("R2 duty held through delay", duty_code, 127);
    wait_n(1);
    chk("R8 rise mid-ramp reloads min", duty_code, 1);

    // reset in mid-ramp (R10)
    do_reset();

    // tick pacing at half rate (R6)
    @(negedge clk);
    duty_min = 7'd100; duty_max = 7'd127; rise_slew = 16'd0; fall_slew = 16'd1;
    half_rate = 1'b1;
    trig_in = 1'b1;
    wait_n(3);
    k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    chk("R3 disabled fade-in reaches max", duty_code, 127);
    trig_in = 1'b0;
    k = 0;
    while (duty_code == 7'd127 && k < 500) begin @(negedge clk); k++; end
    chk("R5 first fade-out step code", duty_code, 123);
    c = duty_code;
    k = 0;
    while (duty_code == 7'(c) && k < 500) begin @(negedge clk); k++; end
    chk("R6 step period counts ticks", k, 40);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule